// File: doc/BRIEF.md
# Flag-Setting Arithmetic Logic Unit

This block is the arithmetic stage of a single-bus microcoded datapath. A combinational function unit takes its first operand from a holding-register value and its second from the shared bus, and produces one result each cycle. A small set of per-cycle control lines changes the operands before they reach the adder. One forces the first operand to zero. One inverts every bit of the second operand. One forces the carry-in to one. One feeds the stored carry flag back as the carry-in. With these lines, subtraction, negation, increment and multi-word arithmetic all come from the one adder.

Four status flags (carry, overflow, zero, negative) are computed from every operation. They are kept in a register that only loads when the microinstruction asks for it. Address or offset arithmetic can therefore use the adder without disturbing flags that a later conditional step still needs. The bus and the microcode store are outside this block.

Top module: `ccalu_top`

## Requirements
- R1: With function code 3'b000 (add), `result` equals A' + B' + carry-in modulo 2^W, where A' and B' are the operands after modification.
- R2: When `zero_a` is high, A' is zero for that cycle only. On the next cycle without `zero_a`, the same `y_in` value is used again unchanged.
- R3: When `inv_b` is high, B' is the bitwise inverse of `bus_in`. With `cin_one` also high, an add yields `y_in - bus_in`.
- R4: When `cin_one` is high, the carry-in is 1, whatever `cin_fwd` and the stored carry are.
- R5: When `cin_fwd` is high and `cin_one` is low, the carry-in equals the stored carry flag. This lets a carry chain across successive operations. With both low, the carry-in is 0.
- R6: The other function codes are 3'b001 AND, 3'b010 OR, 3'b011 XOR and 3'b100 pass B'. The reserved codes 3'b101 to 3'b111 also pass B'.
- R7: `flags_q` holds {C, V, Z, N} in bits 3 down to 0. C is the adder carry out of the top bit. V is set when A' and B' share a sign bit and the result's sign bit differs. Z is set when the result is all zeros. N is the result's top bit. Every non-add function yields C = 0 and V = 0.
- R8: `flags_q` loads the flags of the current operation at a rising clock edge only when `set_cc` is high. Otherwise it holds its value.
- R9: While `rst_n` is low, `flags_q` is all zeros. The zeroing happens without waiting for a clock.
- R10: After `rst_n` rises, the flag register stays in reset for two further rising edges. During those edges a `set_cc` request is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| y_in | input | W | First operand, from the holding register |
| bus_in | input | W | Second operand, from the bus |
| zero_a | input | 1 | Replace the first operand by zero |
| inv_b | input | 1 | Invert the second operand |
| cin_one | input | 1 | Force carry-in to 1 |
| cin_fwd | input | 1 | Use stored carry flag as carry-in |
| func | input | 3 | Function select |
| set_cc | input | 1 | Load the flag register this cycle |
| result | output | W | Combinational result |
| flags_q | output | 4 | Stored flags {C, V, Z, N} |

## Verification
The bench aims at the carries and sign boundaries: an all-ones plus one and a largest-positive plus one. A unit that took carry or overflow from the wrong operands would report the wrong C or V there. Subtraction with equal and unequal operands exposes an inversion that is applied to the wrong operand or left out. A two-word add chained through the stored carry fails if the forwarded carry is ignored. Running both carry-in lines together shows whether priority is wrong. Operations run with `set_cc` low that would produce quite different flags catch a flag register that loads on every cycle. A reset applied mid-run catches clearing that waits for a clock.

// File: rtl/ccalu_pkg.sv
package ccalu_pkg;

  localparam int FN_W = 3;

  localparam logic [FN_W-1:0] FN_ADD  = 3'b000;
  localparam logic [FN_W-1:0] FN_AND  = 3'b001;
  localparam logic [FN_W-1:0] FN_OR   = 3'b010;
  localparam logic [FN_W-1:0] FN_XOR  = 3'b011;
  localparam logic [FN_W-1:0] FN_PASS = 3'b100;

  // Stored status word, carry in the top bit
  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } ccr_t;

  localparam int CCR_W = $bits(ccr_t);

endpackage

// File: rtl/ccalu_rstsync.sv
module ccalu_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ccalu_opmod.sv
module ccalu_opmod #(
  parameter int W = 16
) (
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] bus_i,
  input  logic         zero_a_i,
  input  logic         inv_b_i,
  input  logic         cin_one_i,
  input  logic         cin_fwd_i,
  input  logic         c_stored_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         cin_o
);

  always_comb begin
    a_o = zero_a_i ? '0 : y_i;
    b_o = inv_b_i ? ~bus_i : bus_i;
    // forced one takes priority over the forwarded carry
    if (cin_one_i)      cin_o = 1'b1;
    else if (cin_fwd_i) cin_o = c_stored_i;
    else                cin_o = 1'b0;
  end

endmodule

// File: rtl/ccalu_core.sv
module ccalu_core
  import ccalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            cin_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [W-1:0]    res_o,
  output ccr_t            flags_o
);

  localparam int MSB = W - 1;

  logic [W:0]   sum_w;
  logic [W-1:0] sum_lo;
  logic         add_ovf;

  always_comb begin
    sum_w   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_lo  = sum_w[W-1:0];
    add_ovf = (a_i[MSB] == b_i[MSB]) && (sum_lo[MSB] != a_i[MSB]);
  end

  always_comb begin
    flags_o = '0;
    unique case (fn_i)
      FN_ADD: begin
        res_o     = sum_lo;
        flags_o.c = sum_w[W];
        flags_o.v = add_ovf;
      end
      FN_AND:  res_o = a_i & b_i;
      FN_OR:   res_o = a_i | b_i;
      FN_XOR:  res_o = a_i ^ b_i;
      default: res_o = b_i;
    endcase
    flags_o.z = (res_o == '0);
    flags_o.n = res_o[MSB];
  end

endmodule

// File: rtl/ccalu_flagreg.sv
module ccalu_flagreg
  import ccalu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  ccr_t d_i,
  output ccr_t q_o
);

  ccr_t q_r;
  ccr_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

endmodule

// File: rtl/ccalu_top.sv
module ccalu_top
  import ccalu_pkg::*;
#(
  parameter int W         = 16,
  parameter int RST_STAGE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    y_in,
  input  logic [W-1:0]    bus_in,
  input  logic            zero_a,
  input  logic            inv_b,
  input  logic            cin_one,
  input  logic            cin_fwd,
  input  logic [FN_W-1:0] func,
  input  logic            set_cc,
  output logic [W-1:0]    result,
  output logic [CCR_W-1:0] flags_q
);

  logic         rst_sync_n;
  logic [W-1:0] a_mod;
  logic [W-1:0] b_mod;
  logic         cin_sel;
  ccr_t         ccr_nxt;
  ccr_t         ccr_q;

  ccalu_rstsync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ccalu_opmod #(.W(W)) u_opmod (
    .y_i        (y_in),
    .bus_i      (bus_in),
    .zero_a_i   (zero_a),
    .inv_b_i    (inv_b),
    .cin_one_i  (cin_one),
    .cin_fwd_i  (cin_fwd),
    .c_stored_i (ccr_q.c),
    .a_o        (a_mod),
    .b_o        (b_mod),
    .cin_o      (cin_sel)
  );

  ccalu_core #(.W(W)) u_core (
    .a_i     (a_mod),
    .b_i     (b_mod),
    .cin_i   (cin_sel),
    .fn_i    (func),
    .res_o   (result),
    .flags_o (ccr_nxt)
  );

  ccalu_flagreg u_ccr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (set_cc),
    .d_i    (ccr_nxt),
    .q_o    (ccr_q)
  );

  assign flags_q = ccr_q;

endmodule

// File: rtl/ccalu_chk.sv
module ccalu_chk
  import ccalu_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic [W-1:0]      y_in,
  input logic [W-1:0]      bus_in,
  input logic              zero_a,
  input logic              inv_b,
  input logic              cin_one,
  input logic              cin_fwd,
  input logic [FN_W-1:0]   func,
  input logic              set_cc,
  input logic [W-1:0]      result,
  input logic [CCR_W-1:0]  flags_q,
  input logic [CCR_W-1:0]  ccr_nxt
);

  // R8: no load request, stored flags do not move
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !set_cc |=> $stable(flags_q));

  // R8: load request captures the function unit's flags
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    set_cc |=> flags_q == $past(ccr_nxt));

  // R7: zero and negative flags follow the captured result
  a_r7_zn: assert property (@(posedge clk) disable iff (!rst_sync_n)
    set_cc |=> (flags_q[1] == ($past(result) == '0)) && (flags_q[0] == $past(result[W-1])));

  // R7: non-add functions leave carry and overflow clear
  a_r7_logic_cv: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (set_cc && func != FN_ADD) |=> flags_q[3:2] == 2'b00);

  // R4: forced carry wins over forwarding
  a_r4_cin_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (func == FN_ADD && zero_a && !inv_b && cin_one && cin_fwd) |-> result == bus_in + 1'b1);

  // R2: zeroed first operand makes an add pass the bus
  a_r2_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (func == FN_ADD && zero_a && !inv_b && !cin_one && !cin_fwd) |-> result == bus_in);

  // R3: inverted bus with forced carry subtracts
  a_r3_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (func == FN_ADD && !zero_a && inv_b && cin_one) |-> result == W'(y_in - bus_in));

  // R9: flags cleared whenever reset is held
  always @(posedge clk) begin
    if (!rst_n) a_r9_reset: assert (flags_q == '0);
  end

  // R10: during synchronised release the register stays cleared
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |=> $past(flags_q) == '0);

endmodule

bind ccalu_top ccalu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .y_in       (y_in),
  .bus_in     (bus_in),
  .zero_a     (zero_a),
  .inv_b      (inv_b),
  .cin_one    (cin_one),
  .cin_fwd    (cin_fwd),
  .func       (func),
  .set_cc     (set_cc),
  .result     (result),
  .flags_q    (flags_q),
  .ccr_nxt    (ccr_nxt)
);

// File: tb/sim_ccalu_top.sv
module sim_ccalu_top;

  localparam int W    = 16;
  localparam int HALF = 10;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] y_in;
  logic [W-1:0] bus_in;
  logic         zero_a;
  logic         inv_b;
  logic         cin_one;
  logic         cin_fwd;
  logic [2:0]   func;
  logic         set_cc;
  logic [W-1:0] result;
  logic [3:0]   flags_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [3:0] mfl;

  ccalu_top #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .y_in(y_in), .bus_in(bus_in),
    .zero_a(zero_a), .inv_b(inv_b), .cin_one(cin_one), .cin_fwd(cin_fwd),
    .func(func), .set_cc(set_cc), .result(result), .flags_q(flags_q)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference: integer arithmetic per the requirements
  task automatic model(input logic [W-1:0] y, input logic [W-1:0] b,
                       input logic za, input logic ib, input logic c1, input logic cf,
                       input logic [2:0] fn, input logic [3:0] fl,
                       output logic [W-1:0] r, output logic [3:0] nf);
    longint unsigned av, bv, s, mask;
    int ci;
    mask = (64'd1 << W) - 1;
    av = za ? 0 : longint'(y);
    bv = ib ? (~longint'(b)) & mask : longint'(b);
    ci = c1 ? 1 : (cf ? int'(fl[3]) : 0);
    nf = 4'b0000;
    case (fn)
      3'd0: begin
        s = av + bv + longint'(ci);
        r = W'(s & mask);
        nf[3] = ((s >> W) & 1) != 0;
        nf[2] = (((av >> (W-1)) & 1) == ((bv >> (W-1)) & 1)) &&
                (r[W-1] != (((av >> (W-1)) & 1) != 0));
      end
      3'd1: r = W'(av & bv);
      3'd2: r = W'(av | bv);
      3'd3: r = W'(av ^ bv);
      default: r = W'(bv);
    endcase
    nf[1] = (r == 0);
    nf[0] = r[W-1];
  endtask

  // starts and ends at a falling edge
  task automatic step(input logic [W-1:0] y, input logic [W-1:0] b,
                      input logic za, input logic ib, input logic c1, input logic cf,
                      input logic [2:0] fn, input logic scc, input string tag);
    logic [W-1:0] er;
    logic [3:0]   nf;
    y_in = y; bus_in = b; zero_a = za; inv_b = ib;
    cin_one = c1; cin_fwd = cf; func = fn; set_cc = scc;
    #2;
    model(y, b, za, ib, c1, cf, fn, mfl, er, nf);
    chk({tag, " result"}, result, er);
    @(posedge clk);
    if (scc) mfl = nf;
    @(negedge clk);
    chk({tag, " flags"}, W'(flags_q), W'(mfl));
  endtask

  initial begin
    #(2*HALF*200000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; y_in = '0; bus_in = '0; zero_a = 0; inv_b = 0;
    cin_one = 0; cin_fwd = 0; func = 3'd0; set_cc = 0; mfl = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R9 reset flags", W'(flags_q), '0);
    // R10: request a load that would set Z right at release; must be dropped
    rst_n = 1'b1; set_cc = 1'b1;
    @(negedge clk);
    chk("R10 release ignores set_cc", W'(flags_q), '0);
    set_cc = 1'b0;
    repeat (3) @(negedge clk);

    step(16'h1234, 16'h1111, 0,0,0,0, 3'd0, 1, "R1 add plain");
    step(16'hFFFF, 16'h0001, 0,0,0,0, 3'd0, 1, "R1 R7 carry out zero");
    step(16'h7FFF, 16'h0001, 0,0,0,0, 3'd0, 1, "R7 overflow");
    step(16'h8000, 16'h8000, 0,0,0,0, 3'd0, 1, "R7 neg overflow");
    step(16'h0005, 16'h0007, 0,1,1,0, 3'd0, 1, "R3 subtract neg");
    step(16'h0005, 16'h0005, 0,1,1,0, 3'd0, 1, "R3 subtract equal");
    step(16'h4000, 16'h0003, 1,0,0,0, 3'd0, 1, "R2 zero a");
    step(16'h4000, 16'h0003, 0,0,0,0, 3'd0, 1, "R2 y reused");
    step(16'h0000, 16'h0000, 0,0,0,0, 3'd0, 0, "R8 hold on zero");
    step(16'hFFFF, 16'hFFFF, 0,0,0,0, 3'd0, 0, "R8 hold on carry");
    step(16'hFFFF, 16'h0001, 0,0,0,0, 3'd0, 1, "R5 setup carry");
    step(16'h0010, 16'h0020, 0,0,0,1, 3'd0, 0, "R5 forward one");
    step(16'h0001, 16'h0001, 0,0,0,0, 3'd0, 1, "R5 clear carry");
    step(16'h0010, 16'h0020, 0,0,0,1, 3'd0, 0, "R5 forward zero");
    step(16'h0000, 16'h0100, 1,0,1,1, 3'd0, 1, "R4 priority");
    step(16'hF0F0, 16'hFF00, 0,0,0,0, 3'd1, 1, "R6 and");
    step(16'hF0F0, 16'h0F0F, 0,0,0,0, 3'd2, 1, "R6 or");
    step(16'hAAAA, 16'hAAAA, 0,0,0,0, 3'd3, 1, "R6 R7 xor zero");
    step(16'h1234, 16'h8765, 0,0,0,0, 3'd4, 1, "R6 pass");
    step(16'h1234, 16'h0F0F, 0,1,0,0, 3'd5, 1, "R6 reserved 5");
    step(16'h1234, 16'h0F0F, 0,0,0,0, 3'd7, 1, "R6 reserved 7");

    // R5: two-word add 0x0001FFFF + 0x00000001 through the stored carry
    step(16'hFFFF, 16'h0001, 0,0,0,0, 3'd0, 1, "R5 low word");
    begin
      logic [W-1:0] hi;
      y_in = 16'h0001; bus_in = 16'h0000; cin_fwd = 1; func = 3'd0; set_cc = 1;
      #2; hi = result;
      chk("R5 chained sum", W'({hi, 16'h0000} >> W), 16'h0002);
      @(negedge clk);
      mfl = 4'b0000;
      cin_fwd = 0; set_cc = 0;
    end

    for (int i = 0; i < 60; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(W'($urandom), W'($urandom), rv[0], rv[1], rv[2], rv[3],
           3'(rv[6:4]), rv[7], "R1 R7 random");
    end

    // R9: asynchronous clear mid-run
    step(16'h8000, 16'h8000, 0,0,0,0, 3'd0, 1, "R9 preload");
    #3 rst_n = 1'b0;
    #2 chk("R9 async clear", W'(flags_q), '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule